// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block services one load miss at a time by refilling a full cache line from the next memory level. The line (64 bytes by default) moves as a burst of 64-bit beats. The burst starts at the beat that holds the missed word and wraps around the end of the line. The missed word is handed to the core in the same cycle it arrives, so the core can restart early. Every beat, including that first one, is also written into the cache data array in the cycle it is accepted. The tag write, which also marks the line valid, follows one cycle after the last beat. A partly filled line therefore never looks like a hit.

The miss address is already physical and is used as given. While a refill is in progress, the core can present a probe address. The block raises a stall for a load to the line being filled until that load's beat has been written or is arriving in the current cycle. A load to any other line stalls until the refill has fully finished.

The miss input and both memory channels use valid/ready:
- Miss channel: a miss is taken only in a cycle where `miss_valid` and `miss_ready` are both high.
- Request channel: once `mem_req_valid` is raised, it stays high with a stable address until `mem_req_ready` is seen.
- Response channel: a beat counts only when `mem_rsp_valid` and `mem_rsp_ready` are both high. A cycle without valid is a bubble that changes nothing.

The array write port, the forward strobe and the probe stall are plain signals with no back-pressure.

Top module: `cwf_refill`

## Requirements
- R1: While reset is asserted, `miss_ready` is 1 and `mem_req_valid`, `fwd_valid`, `arr_data_we` and `arr_tag_we` are 0.
- R2: In the cycle after a miss is accepted, `mem_req_valid` rises with `mem_req_addr` equal to the miss address with bits [2:0] cleared (line base plus critical beat times 8). Valid and address hold unchanged until `mem_req_ready` is sampled high.
- R3: The k-th accepted beat (k = 0..7) is written at beat index (s + k) mod 8, where s is miss address bits [5:3].
- R4: `fwd_valid` is high for exactly one cycle per refill, the cycle the first beat is accepted, with `fwd_data` equal to that beat's data. Nothing is forwarded for later beats.
- R5: Each accepted beat drives `arr_data_we`=1 in the same cycle, with `arr_data_idx` = miss address bits [11:6] and `arr_data` = the response data. No beat index is written twice in one refill.
- R6: `arr_tag_we` pulses once, in the cycle after the eighth beat is accepted, with `arr_tag` = miss address bits [31:12] and `arr_tag_idx` = bits [11:6]. It is never high earlier in the refill.
- R7: In a fill cycle with `mem_rsp_valid` low, there is no array write and no forward, and the beat position does not advance.
- R8: For a valid probe to the line being filled, `probe_stall` is 1 exactly when the probed beat (probe address bits [5:3]) has not been written in an earlier cycle and is not being accepted in the current cycle.
- R9: A valid probe to any other line stalls from miss acceptance up to and including the tag-write cycle. When no refill is in progress, `probe_stall` is 0.
- R10: `miss_ready` drops after a miss is accepted and returns to 1 in the cycle after the tag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Load miss presented |
| miss_ready | output | 1 | Block idle, miss can be taken |
| miss_addr | input | 32 | Physical address of the missed load |
| mem_req_valid | output | 1 | Line request toward memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Line base plus critical beat offset |
| mem_rsp_valid | input | 1 | Beat data present |
| mem_rsp_ready | output | 1 | Block accepts beats (during fill) |
| mem_rsp_data | input | 64 | Beat data |
| arr_data_we | output | 1 | Data array write strobe |
| arr_data_idx | output | 6 | Set index for data write |
| arr_beat | output | 3 | Beat position within the line |
| arr_data | output | 64 | Data written to the array |
| arr_tag_we | output | 1 | Tag write, sets the line valid |
| arr_tag_idx | output | 6 | Set index for tag write |
| arr_tag | output | 20 | Tag value |
| fwd_valid | output | 1 | Critical word delivered to core |
| fwd_data | output | 64 | Critical word |
| probe_valid | input | 1 | Core load presented for hazard check |
| probe_addr | input | 32 | Address of that load |
| probe_stall | output | 1 | Load must wait |

## Verification
The first accepted beat is both forwarded to the core and written into the data array in one cycle. A probe to that same beat in that cycle must also be released, because the beat is arriving rather than already written. The bench sweeps all eight start beats over several sets and tags. It inserts bubbles and request delays that move the first arrival to different cycles. In each cycle it checks the forward, the array write and the probe stall against a beat mask and a wrap order that it computes itself.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    CW_IDLE = 2'd0,
    CW_REQ  = 2'd1,
    CW_FILL = 2'd2,
    CW_DONE = 2'd3
  } cw_state_e;
endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
  parameter int BEATS  = 8,
  parameter int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BEAT_W-1:0] start,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              first,
  output logic              last
);
  logic [BEAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // wrap-around order: position modulo the power-of-two beat count
  assign beat_idx = start + cnt_q;
  assign first    = (cnt_q == '0);
  assign last     = (cnt_q == BEAT_W'(BEATS - 1));

  // R3
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !last) |=> (beat_idx == BEAT_W'($past(beat_idx) + 1'b1)));
endmodule

// File: rtl/cwf_fill_track.sv
module cwf_fill_track #(
  parameter int BEATS  = 8,
  parameter int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [BEAT_W-1:0] wr_beat,
  input  logic              busy,
  input  logic              probe_valid,
  input  logic              probe_same,
  input  logic [BEAT_W-1:0] probe_beat,
  output logic [BEATS-1:0]  mask,
  output logic              probe_stall
);
  logic [BEATS-1:0] mask_q;
  logic             beat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (clear)   mask_q <= '0;
    else if (wr_en)   mask_q[wr_beat] <= 1'b1;
  end

  assign mask        = mask_q;
  assign beat_ready  = mask_q[probe_beat] || (wr_en && (wr_beat == probe_beat));
  assign probe_stall = probe_valid && busy && (!probe_same || !beat_ready);

  // R5
  no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mask_q[wr_beat]);
endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BITS  = 64,
  parameter int SET_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 miss_valid,
  output logic                 miss_ready,
  input  logic [ADDR_W-1:0]    miss_addr,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  output logic                 mem_rsp_ready,
  input  logic [BEAT_BITS-1:0] mem_rsp_data,
  output logic                 arr_data_we,
  output logic [SET_W-1:0]     arr_data_idx,
  output logic [$clog2(LINE_BYTES/(BEAT_BITS/8))-1:0] arr_beat,
  output logic [BEAT_BITS-1:0] arr_data,
  output logic                 arr_tag_we,
  output logic [SET_W-1:0]     arr_tag_idx,
  output logic [ADDR_W-$clog2(LINE_BYTES)-SET_W-1:0] arr_tag,
  output logic                 fwd_valid,
  output logic [BEAT_BITS-1:0] fwd_data,
  input  logic                 probe_valid,
  input  logic [ADDR_W-1:0]    probe_addr,
  output logic                 probe_stall
);
  localparam int BEAT_BYTES = BEAT_BITS / 8;
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BSEL_W     = $clog2(BEAT_BYTES);
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int LINE_W     = ADDR_W - OFF_W;

  cw_state_e         state_q;
  logic [LINE_W-1:0] line_q;
  logic [BEAT_W-1:0] start_q;
  logic              miss_fire, req_fire, beat_fire;
  logic              seq_first, seq_last;
  logic [BEAT_W-1:0] seq_beat;
  logic [BEATS-1:0]  fill_mask;
  logic              busy;
  logic              unused_low_bits;

  assign unused_low_bits = ^{miss_addr[BSEL_W-1:0], probe_addr[BSEL_W-1:0]};

  assign miss_ready    = (state_q == CW_IDLE);
  assign miss_fire     = miss_valid && miss_ready;
  assign mem_req_valid = (state_q == CW_REQ);
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign mem_rsp_ready = (state_q == CW_FILL);
  assign beat_fire     = mem_rsp_valid && mem_rsp_ready;
  assign busy          = (state_q != CW_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CW_IDLE;
      line_q  <= '0;
      start_q <= '0;
    end else begin
      case (state_q)
        CW_IDLE: if (miss_fire) begin
          line_q  <= miss_addr[ADDR_W-1:OFF_W];
          start_q <= miss_addr[OFF_W-1:BSEL_W];
          state_q <= CW_REQ;
        end
        CW_REQ:  if (req_fire) state_q <= CW_FILL;
        CW_FILL: if (beat_fire && seq_last) state_q <= CW_DONE;
        default: state_q <= CW_IDLE;
      endcase
    end
  end

  cwf_beat_seq #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (miss_fire),
    .start    (start_q),
    .step     (beat_fire),
    .beat_idx (seq_beat),
    .first    (seq_first),
    .last     (seq_last)
  );

  cwf_fill_track #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (miss_fire),
    .wr_en       (beat_fire),
    .wr_beat     (seq_beat),
    .busy        (busy),
    .probe_valid (probe_valid),
    .probe_same  (probe_addr[ADDR_W-1:OFF_W] == line_q),
    .probe_beat  (probe_addr[OFF_W-1:BSEL_W]),
    .mask        (fill_mask),
    .probe_stall (probe_stall)
  );

  assign mem_req_addr = {line_q, start_q, {BSEL_W{1'b0}}};

  // data array write and core forward leave from the same accepted beat
  assign arr_data_we  = beat_fire;
  assign arr_data_idx = line_q[SET_W-1:0];
  assign arr_beat     = seq_beat;
  assign arr_data     = mem_rsp_data;
  assign fwd_valid    = beat_fire && seq_first;
  assign fwd_data     = mem_rsp_data;

  assign arr_tag_we   = (state_q == CW_DONE);
  assign arr_tag_idx  = line_q[SET_W-1:0];
  assign arr_tag      = line_q[LINE_W-1:SET_W];

  // R6
  tag_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_tag_we |-> (&fill_mask));
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R4
  fwd_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (arr_data_we && (arr_beat == start_q)));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);
endmodule

// File: tb/tb_cwf_refill.sv
module tb_cwf_refill;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid, miss_ready;
  logic [31:0] miss_addr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_rsp_data;
  logic        arr_data_we;
  logic [5:0]  arr_data_idx;
  logic [2:0]  arr_beat;
  logic [63:0] arr_data;
  logic        arr_tag_we;
  logic [5:0]  arr_tag_idx;
  logic [19:0] arr_tag;
  logic        fwd_valid;
  logic [63:0] fwd_data;
  logic        probe_valid;
  logic [31:0] probe_addr;
  logic        probe_stall;

  int vec = 0;
  int bad = 0;

  always #4 clk = ~clk;

  cwf_refill dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .arr_data_we(arr_data_we), .arr_data_idx(arr_data_idx), .arr_beat(arr_beat), .arr_data(arr_data),
    .arr_tag_we(arr_tag_we), .arr_tag_idx(arr_tag_idx), .arr_tag(arr_tag),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_stall(probe_stall)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_data(input int t, input int b);
    return {16'hD00D, 16'(t), 16'hBEEF ^ 16'(b), 16'(b * 7 + t)};
  endfunction

  task automatic run_trial(input int t, input logic [19:0] tag, input logic [5:0] set,
                           input logic [2:0] st, input bit gaps);
    logic [7:0] wm;
    int got;
    int c;
    @(negedge clk);
    miss_valid  = 1'b1;
    miss_addr   = {tag, set, st, 3'b101};
    probe_valid = 1'b1;
    probe_addr  = {tag ^ 20'h1, set, 6'h0};
    #1;
    chk("R10 ready when idle", 64'(miss_ready), 64'd1);
    chk("R9 idle no stall", 64'(probe_stall), 64'd0);
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    chk("R10 busy after accept", 64'(miss_ready), 64'd0);
    chk("R2 req valid", 64'(mem_req_valid), 64'd1);
    chk("R2 req addr", 64'(mem_req_addr), 64'({tag, set, st, 3'b000}));
    chk("R9 other line stalls in req", 64'(probe_stall), 64'd1);
    for (int d = 0; d < t % 3; d++) begin
      @(negedge clk);
      #1;
      chk("R2 req held valid", 64'(mem_req_valid), 64'd1);
      chk("R2 req held addr", 64'(mem_req_addr), 64'({tag, set, st, 3'b000}));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    wm  = '0;
    got = 0;
    c   = 0;
    while (got < 8) begin
      bit rv;
      logic [2:0] eb;
      logic [2:0] pb;
      bit same;
      rv = gaps ? (((c * 3 + t) % 4) != 0) : 1'b1;
      eb = 3'((int'(st) + got) % 8);
      mem_rsp_valid = rv;
      mem_rsp_data  = beat_data(t, int'(eb));
      same = (c % 3) != 2;
      pb   = 3'((c + t) % 8);
      probe_addr = same ? {tag, set, pb, 3'b010} : {tag + 20'h3, set, pb, 3'b000};
      #1;
      chk("R7 rsp ready in fill", 64'(mem_rsp_ready), 64'd1);
      if (rv) begin
        chk("R5 data write", 64'(arr_data_we), 64'd1);
        chk("R3 beat order", 64'(arr_beat), 64'(eb));
        chk("R5 data idx", 64'(arr_data_idx), 64'(set));
        chk("R5 data value", arr_data, beat_data(t, int'(eb)));
        chk("R4 forward strobe", 64'(fwd_valid), 64'(got == 0));
        if (got == 0) chk("R4 forward data", fwd_data, beat_data(t, int'(st)));
      end else begin
        chk("R7 no write on bubble", 64'(arr_data_we), 64'd0);
        chk("R7 no forward on bubble", 64'(fwd_valid), 64'd0);
      end
      chk("R6 no early tag", 64'(arr_tag_we), 64'd0);
      if (same)
        chk("R8 same line stall", 64'(probe_stall), 64'(!(wm[pb] || (rv && eb == pb))));
      else
        chk("R9 other line stall", 64'(probe_stall), 64'd1);
      if (rv) begin
        wm[eb] = 1'b1;
        got++;
      end
      c++;
      @(negedge clk);
    end
    mem_rsp_valid = 1'b0;
    probe_addr = {tag + 20'h3, set, 6'h0};
    #1;
    chk("R6 tag write", 64'(arr_tag_we), 64'd1);
    chk("R6 tag value", 64'(arr_tag), 64'(tag));
    chk("R6 tag idx", 64'(arr_tag_idx), 64'(set));
    chk("R10 busy in tag cycle", 64'(miss_ready), 64'd0);
    chk("R9 other line stalls in tag cycle", 64'(probe_stall), 64'd1);
    chk("R5 no write in tag cycle", 64'(arr_data_we), 64'd0);
    @(negedge clk);
    #1;
    chk("R6 single tag pulse", 64'(arr_tag_we), 64'd0);
    chk("R10 ready after tag", 64'(miss_ready), 64'd1);
    chk("R9 idle no stall", 64'(probe_stall), 64'd0);
    probe_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    miss_valid = 1'b0; miss_addr = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    probe_valid = 1'b0; probe_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset miss_ready", 64'(miss_ready), 64'd1);
    chk("R1 reset req", 64'(mem_req_valid), 64'd0);
    chk("R1 reset fwd", 64'(fwd_valid), 64'd0);
    chk("R1 reset data we", 64'(arr_data_we), 64'd0);
    chk("R1 reset tag we", 64'(arr_tag_we), 64'd0);
    rst_n = 1'b1;
    for (int g = 0; g < 3; g++) begin
      for (int s = 0; s < 8; s++) begin
        int t;
        t = g * 8 + s;
        run_trial(t, 20'hA5000 + 20'(g * 257 + s), 6'((s * 5 + g * 11) % 64), 3'(s), g != 0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule